// File: doc/BRIEF.md
# Opcode Group Classifier and Dispatch

This block sits right behind the instruction register of a microcoded processor core. It accepts the first byte of an instruction together with a pending-interrupt flag. It sorts that byte into a structural group and then starts the right kind of execution. The grouping is done by a two-level AND/OR product-term array. Each term matches a care-masked pattern over the nine input bits, and the OR plane merges the matched terms into fifteen control lines. The lines describe how an opcode is built: whether it carries a width bit or a direction bit, whether an addressing byte follows, whether an immediate follows, and whether the operation runs in hardwired logic or in microcode.

A small sequencer uses those lines to dispatch the instruction. Hardwired one-byte operations get a single fire pulse carrying the opcode. Microcoded operations get a start pulse with a microcode entry address built from the opcode. When an addressing byte follows, the sequencer first requests the memory-addressing subroutine and waits for it to report completion. A pending interrupt overrides the opcode. It forces the interrupt-entry group and a fixed entry address, and it never calls the addressing subroutine. The product-term table is a parameter, so the grouping can be changed without touching the logic.

Top module: `opclass_dispatch`

## Requirements
- R1: `op_ready` is high only while the block is idle. An opcode and the interrupt flag are captured on a clock edge where `op_valid` and `op_ready` are both high. `op_ready` then stays low until dispatch ends. `op_valid` and `op_byte` are ignored while busy, and the captured byte is what appears on `uc_addr`/`hw_op`.
- R2: `ctl_lines` bit meanings: 0 hardwired one-byte op, 1 width bit in opcode bit 0, 2 addressing byte follows, 3 direction bit in opcode bit 1, 4 immediate follows, 5 register in low three bits, 6 accumulator implied, 7 ALU group, 8 segment register op, 9 branch, 10 string op, 11 prefix, 12 halt, 13 interrupt entry, 14 width bit in opcode bit 3. The lines are loaded one cycle after capture, hold until the next capture, and read 0 after reset.
- R3: With the flag low, the lines for each opcode (hex) are: 00-3F with bit2=0 → {7,2,1,3}; 00-3F with bit2=1, bit1=0 → {7,1,6,4}; 00-3F with bits2:1=11 → {8}; 40-4F → {5,7}; 50-5F → {5}; 60-7F → {9,4}; 80-8F → {2,1,3}; 90-97 → {5,6}; 98-9F → {0}; A0-AF → {10,1}; B0-BF → {5,4,14}; C0-CF → {9}; D0-DF → {7,2,1}; E0-EF → {9}; F0-F3 → {11,0}; F4 → {12}; F5 → {0}; F6-F7 → {7,2,1}; F8-FD → {0}; FE-FF → {2,1}. This holds for all 256 opcodes.
- R4: With the flag high at capture, `ctl_lines` is exactly bit 13 for any opcode. `uc_start` carries `uc_addr` = 9'h100, and `asub_req` never rises.
- R5: When line 0 is set, `hw_fire` is high for exactly the second cycle after the capturing edge, with `hw_op` equal to the captured opcode. `uc_start` stays low.
- R6: When line 0 and line 2 are clear, `uc_start` is high for exactly the second cycle after the capturing edge, with `uc_addr` = {1'b0, opcode}.
- R7: When line 2 is set, `asub_req` rises in the second cycle after capture and stays high up to and including the cycle in which `asub_done` is sampled high. `uc_start` follows in the next cycle. `asub_done` has no effect at any other time.
- R8: At most one of `uc_start`, `hw_fire` and `asub_req` is high in any cycle. The cycle after a `uc_start` or `hw_fire` pulse has `op_ready` high.
- R9: During and right after reset, `op_ready` is high and `uc_start`, `hw_fire`, `asub_req` and `ctl_lines` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Opcode byte offered |
| op_ready | output | 1 | Block idle and able to take an opcode |
| op_byte | input | 8 | First instruction byte |
| irq_req | input | 1 | Pending interrupt, overrides the opcode |
| asub_req | output | 1 | Addressing subroutine requested (level) |
| asub_done | input | 1 | Addressing subroutine finished |
| uc_start | output | 1 | One-cycle microcode start pulse |
| uc_addr | output | 9 | Microcode entry address |
| hw_fire | output | 1 | One-cycle hardwired-operation pulse |
| hw_op | output | 8 | Opcode for the hardwired operation |
| ctl_lines | output | 15 | Classification lines of the current instruction |

## Verification
The assertions assume that `asub_done` only means something while `asub_req` is high. They also assume the requester drops `op_valid` before the block returns to idle, unless it wants a new opcode taken. Inputs are assumed to change away from the active edge. The stimulus offers each opcode for exactly one capture edge, then deasserts `op_valid` and scrambles `op_byte`. It raises `asub_done` only after a chosen number of request cycles, and it offers a stray opcode only while the addressing subroutine is pending. Every one of the 512 flag/opcode combinations is dispatched and compared with an independently written group map.

// File: rtl/opc_pkg.sv
`timescale 1ns/1ps
package opc_pkg;
  localparam int OP_W = 8;
  localparam int IN_W = OP_W + 1;
  localparam int NL   = 15;
  localparam int NT   = 22;
  localparam int UA_W = OP_W + 1;

  // control line positions
  localparam int LN_HARD   = 0;
  localparam int LN_WIDTH  = 1;
  localparam int LN_MODRM  = 2;
  localparam int LN_DIR    = 3;
  localparam int LN_IMM    = 4;
  localparam int LN_REGLO  = 5;
  localparam int LN_ACC    = 6;
  localparam int LN_ALU    = 7;
  localparam int LN_SEG    = 8;
  localparam int LN_BRANCH = 9;
  localparam int LN_STRING = 10;
  localparam int LN_PREFIX = 11;
  localparam int LN_HALT   = 12;
  localparam int LN_IRQ    = 13;
  localparam int LN_WIDE3  = 14;

  localparam logic [NL-1:0] F_HARD   = NL'(1) << LN_HARD;
  localparam logic [NL-1:0] F_WIDTH  = NL'(1) << LN_WIDTH;
  localparam logic [NL-1:0] F_MODRM  = NL'(1) << LN_MODRM;
  localparam logic [NL-1:0] F_DIR    = NL'(1) << LN_DIR;
  localparam logic [NL-1:0] F_IMM    = NL'(1) << LN_IMM;
  localparam logic [NL-1:0] F_REGLO  = NL'(1) << LN_REGLO;
  localparam logic [NL-1:0] F_ACC    = NL'(1) << LN_ACC;
  localparam logic [NL-1:0] F_ALU    = NL'(1) << LN_ALU;
  localparam logic [NL-1:0] F_SEG    = NL'(1) << LN_SEG;
  localparam logic [NL-1:0] F_BRANCH = NL'(1) << LN_BRANCH;
  localparam logic [NL-1:0] F_STRING = NL'(1) << LN_STRING;
  localparam logic [NL-1:0] F_PREFIX = NL'(1) << LN_PREFIX;
  localparam logic [NL-1:0] F_HALT   = NL'(1) << LN_HALT;
  localparam logic [NL-1:0] F_IRQ    = NL'(1) << LN_IRQ;
  localparam logic [NL-1:0] F_WIDE3  = NL'(1) << LN_WIDE3;

  // one product term: input bits under care must equal want
  typedef struct packed {
    logic [IN_W-1:0] care;
    logic [IN_W-1:0] want;
    logic [NL-1:0]   lines;
  } pterm_t;

  // input layout {irq, opcode}; every opcode term cares about irq == 0,
  // so a pending interrupt leaves only the last term matching
  localparam pterm_t [NT-1:0] TERM_TABLE = '{
    '{9'b1_1100_0100, 9'b0_0000_0000, F_ALU | F_MODRM | F_WIDTH | F_DIR},
    '{9'b1_1100_0110, 9'b0_0000_0100, F_ALU | F_WIDTH | F_ACC | F_IMM},
    '{9'b1_1100_0110, 9'b0_0000_0110, F_SEG},
    '{9'b1_1110_0000, 9'b0_0100_0000, F_REGLO},
    '{9'b1_1111_0000, 9'b0_0100_0000, F_ALU},
    '{9'b1_1110_0000, 9'b0_0110_0000, F_BRANCH | F_IMM},
    '{9'b1_1111_0000, 9'b0_1000_0000, F_MODRM | F_WIDTH | F_DIR},
    '{9'b1_1111_1000, 9'b0_1001_0000, F_REGLO | F_ACC},
    '{9'b1_1111_1000, 9'b0_1001_1000, F_HARD},
    '{9'b1_1111_0000, 9'b0_1010_0000, F_STRING | F_WIDTH},
    '{9'b1_1111_0000, 9'b0_1011_0000, F_REGLO | F_IMM | F_WIDE3},
    '{9'b1_1111_0000, 9'b0_1100_0000, F_BRANCH},
    '{9'b1_1111_0000, 9'b0_1101_0000, F_ALU | F_MODRM | F_WIDTH},
    '{9'b1_1111_0000, 9'b0_1110_0000, F_BRANCH},
    '{9'b1_1111_1100, 9'b0_1111_0000, F_PREFIX | F_HARD},
    '{9'b1_1111_1111, 9'b0_1111_0100, F_HALT},
    '{9'b1_1111_1111, 9'b0_1111_0101, F_HARD},
    '{9'b1_1111_1110, 9'b0_1111_0110, F_ALU | F_MODRM | F_WIDTH},
    '{9'b1_1111_1100, 9'b0_1111_1000, F_HARD},
    '{9'b1_1111_1110, 9'b0_1111_1100, F_HARD},
    '{9'b1_1111_1110, 9'b0_1111_1110, F_MODRM | F_WIDTH},
    '{9'b1_0000_0000, 9'b1_0000_0000, F_IRQ}
  };

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLASSIFY,
    ST_ADDR_SUB,
    ST_MICRO_START,
    ST_HW_EXEC
  } disp_state_e;

  function automatic logic term_hit(logic [IN_W-1:0] in_v,
                                    logic [IN_W-1:0] care,
                                    logic [IN_W-1:0] want);
    return (in_v & care) == want;
  endfunction

  function automatic logic [UA_W-1:0] micro_entry(logic irq,
                                                  logic [OP_W-1:0] op,
                                                  logic [UA_W-1:0] irq_addr);
    return irq ? irq_addr : {1'b0, op};
  endfunction
endpackage

// File: rtl/opc_and_plane.sv
`timescale 1ns/1ps
module opc_and_plane
  import opc_pkg::*;
#(
  parameter pterm_t [NT-1:0] TABLE = TERM_TABLE
) (
  input  logic [IN_W-1:0] in_i,
  output logic [NT-1:0]   hit_o
);
  for (genvar t = 0; t < NT; t++) begin : g_term
    assign hit_o[t] = term_hit(in_i, TABLE[t].care, TABLE[t].want);
  end
endmodule

// File: rtl/opc_or_plane.sv
`timescale 1ns/1ps
module opc_or_plane
  import opc_pkg::*;
#(
  parameter pterm_t [NT-1:0] TABLE = TERM_TABLE
) (
  input  logic [NT-1:0] hit_i,
  output logic [NL-1:0] lines_o
);
  // which terms feed a given output line
  function automatic logic [NT-1:0] column(int l);
    logic [NT-1:0] c;
    for (int t = 0; t < NT; t++) c[t] = TABLE[t].lines[l];
    return c;
  endfunction

  for (genvar l = 0; l < NL; l++) begin : g_line
    localparam logic [NT-1:0] COL = column(l);
    assign lines_o[l] = |(hit_i & COL);
  end
endmodule

// File: rtl/opc_dispatch_fsm.sv
`timescale 1ns/1ps
module opc_dispatch_fsm
  import opc_pkg::*;
#(
  parameter logic [UA_W-1:0] IRQ_UADDR = 9'h100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic [OP_W-1:0] op_byte,
  input  logic            irq_req,
  output logic [IN_W-1:0] cls_in,
  input  logic [NL-1:0]   cls_lines,
  output logic            asub_req,
  input  logic            asub_done,
  output logic            uc_start,
  output logic [UA_W-1:0] uc_addr,
  output logic            hw_fire,
  output logic [OP_W-1:0] hw_op,
  output logic [NL-1:0]   ctl_lines,
  output logic            ev_accept,
  output logic            ev_route_hw,
  output logic            ev_route_sub
);
  disp_state_e     state, state_n;
  logic [OP_W-1:0] op_q;
  logic            irq_q;
  logic [NL-1:0]   lines_q;

  assign ev_accept    = op_valid && (state == ST_IDLE);
  assign ev_route_hw  = (state == ST_CLASSIFY) && cls_lines[LN_HARD];
  assign ev_route_sub = (state == ST_CLASSIFY) && !cls_lines[LN_HARD]
                        && cls_lines[LN_MODRM] && !cls_lines[LN_IRQ];

  always_comb begin
    state_n = state;
    case (state)
      ST_IDLE:        if (op_valid) state_n = ST_CLASSIFY;
      ST_CLASSIFY: begin
        if (ev_route_hw)       state_n = ST_HW_EXEC;
        else if (ev_route_sub) state_n = ST_ADDR_SUB;
        else                   state_n = ST_MICRO_START;
      end
      ST_ADDR_SUB:    if (asub_done) state_n = ST_MICRO_START;
      ST_MICRO_START: state_n = ST_IDLE;
      ST_HW_EXEC:     state_n = ST_IDLE;
      default:        state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      op_q    <= '0;
      irq_q   <= 1'b0;
      lines_q <= '0;
    end else begin
      state <= state_n;
      if (ev_accept) begin
        op_q  <= op_byte;
        irq_q <= irq_req;
      end
      if (state == ST_CLASSIFY) lines_q <= cls_lines;
    end
  end

  assign cls_in    = {irq_q, op_q};
  assign op_ready  = (state == ST_IDLE);
  assign asub_req  = (state == ST_ADDR_SUB);
  assign uc_start  = (state == ST_MICRO_START);
  assign hw_fire   = (state == ST_HW_EXEC);
  assign uc_addr   = micro_entry(irq_q, op_q, IRQ_UADDR);
  assign hw_op     = op_q;
  assign ctl_lines = lines_q;
endmodule

// File: rtl/opclass_dispatch.sv
`timescale 1ns/1ps
module opclass_dispatch
  import opc_pkg::*;
#(
  parameter pterm_t [NT-1:0]  TABLE     = TERM_TABLE,
  parameter logic [UA_W-1:0]  IRQ_UADDR = 9'h100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic [OP_W-1:0] op_byte,
  input  logic            irq_req,
  output logic            asub_req,
  input  logic            asub_done,
  output logic            uc_start,
  output logic [UA_W-1:0] uc_addr,
  output logic            hw_fire,
  output logic [OP_W-1:0] hw_op,
  output logic [NL-1:0]   ctl_lines
);
  // named internal events for the checker
  logic [IN_W-1:0] cls_in;
  logic [NT-1:0]   term_hits;
  logic [NL-1:0]   cls_lines;
  logic [OP_W-1:0] held_op;
  logic            held_irq;
  logic            ev_accept, ev_route_hw, ev_route_sub;

  assign held_op  = cls_in[OP_W-1:0];
  assign held_irq = cls_in[IN_W-1];

  opc_and_plane #(.TABLE(TABLE)) u_and (
    .in_i  (cls_in),
    .hit_o (term_hits)
  );

  opc_or_plane #(.TABLE(TABLE)) u_or (
    .hit_i   (term_hits),
    .lines_o (cls_lines)
  );

  opc_dispatch_fsm #(.IRQ_UADDR(IRQ_UADDR)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .op_ready     (op_ready),
    .op_byte      (op_byte),
    .irq_req      (irq_req),
    .cls_in       (cls_in),
    .cls_lines    (cls_lines),
    .asub_req     (asub_req),
    .asub_done    (asub_done),
    .uc_start     (uc_start),
    .uc_addr      (uc_addr),
    .hw_fire      (hw_fire),
    .hw_op        (hw_op),
    .ctl_lines    (ctl_lines),
    .ev_accept    (ev_accept),
    .ev_route_hw  (ev_route_hw),
    .ev_route_sub (ev_route_sub)
  );
endmodule

// File: rtl/opclass_dispatch_chk.sv
`timescale 1ns/1ps
module opclass_dispatch_chk
  import opc_pkg::*;
#(
  parameter logic [UA_W-1:0] IRQ_UADDR = 9'h100
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic            op_ready,
  input logic            asub_req,
  input logic            asub_done,
  input logic            uc_start,
  input logic [UA_W-1:0] uc_addr,
  input logic            hw_fire,
  input logic [OP_W-1:0] hw_op,
  input logic [NL-1:0]   ctl_lines,
  input logic [OP_W-1:0] held_op,
  input logic            held_irq,
  input logic            ev_route_sub
);
  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_ready |=> !op_ready);

  assert_hold_opcode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !op_ready && $past(!op_ready) |-> $stable(held_op) && $stable(held_irq));

  assert_lines_present_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (uc_start || hw_fire) |-> ctl_lines != '0);

  assert_irq_no_sub_R4: assert property (@(posedge clk) disable iff (!rst_n)
    asub_req |-> !ctl_lines[LN_IRQ]);

  assert_irq_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    uc_start && held_irq |-> uc_addr == IRQ_UADDR && ctl_lines[LN_IRQ]);

  assert_hw_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hw_fire |-> ctl_lines[LN_HARD] && hw_op == held_op);

  assert_micro_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    uc_start |-> !ctl_lines[LN_HARD]);

  assert_sub_before_micro_R7: assert property (@(posedge clk) disable iff (!rst_n)
    uc_start && ctl_lines[LN_MODRM] |-> $past(asub_req && asub_done));

  assert_sub_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_route_sub |=> asub_req && ctl_lines[LN_MODRM]);

  assert_one_action_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({uc_start, hw_fire, asub_req}));

  assert_back_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (uc_start || hw_fire) |=> op_ready);
endmodule

bind opclass_dispatch opclass_dispatch_chk #(.IRQ_UADDR(IRQ_UADDR)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_valid     (op_valid),
  .op_ready     (op_ready),
  .asub_req     (asub_req),
  .asub_done    (asub_done),
  .uc_start     (uc_start),
  .uc_addr      (uc_addr),
  .hw_fire      (hw_fire),
  .hw_op        (hw_op),
  .ctl_lines    (ctl_lines),
  .held_op      (held_op),
  .held_irq     (held_irq),
  .ev_route_sub (ev_route_sub)
);

// File: tb/opclass_dispatch_bench.sv
`timescale 1ns/1ps
module opclass_dispatch_bench;
  // line bits as given in R2
  localparam logic [14:0] K_HW  = 15'h0001, K_W   = 15'h0002, K_MRM = 15'h0004,
                          K_D   = 15'h0008, K_IMM = 15'h0010, K_REG = 15'h0020,
                          K_ACC = 15'h0040, K_ALU = 15'h0080, K_SEG = 15'h0100,
                          K_BR  = 15'h0200, K_STR = 15'h0400, K_PFX = 15'h0800,
                          K_HLT = 15'h1000, K_IRQ = 15'h2000, K_W3  = 15'h4000;
  localparam int WATCHDOG = 100000;

  // {irq, opcode, expected lines}
  localparam logic [23:0] VEC [15] = '{
    {1'b0, 8'h01, 15'h008E}, {1'b0, 8'h05, 15'h00D2}, {1'b0, 8'h0E, 15'h0100},
    {1'b0, 8'h43, 15'h00A0}, {1'b0, 8'h75, 15'h0210}, {1'b0, 8'h9C, 15'h0001},
    {1'b0, 8'hB8, 15'h4030}, {1'b0, 8'hF2, 15'h0801}, {1'b0, 8'hF4, 15'h1000},
    {1'b0, 8'hFF, 15'h0006}, {1'b0, 8'hA5, 15'h0402}, {1'b1, 8'h01, 15'h2000},
    {1'b1, 8'hF2, 15'h2000}, {1'b0, 8'hD3, 15'h0086}, {1'b0, 8'h8B, 15'h000E}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [7:0]  op_byte = 8'h00;
  logic        irq_req = 1'b0;
  logic        asub_req;
  logic        asub_done = 1'b0;
  logic        uc_start;
  logic [8:0]  uc_addr;
  logic        hw_fire;
  logic [7:0]  hw_op;
  logic [14:0] ctl_lines;

  int n_chk = 0;
  int n_fail = 0;
  int n_cyc = 0;

  always #4 clk = ~clk;

  opclass_dispatch u_opclass_dispatch (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_byte(op_byte), .irq_req(irq_req), .asub_req(asub_req),
    .asub_done(asub_done), .uc_start(uc_start), .uc_addr(uc_addr),
    .hw_fire(hw_fire), .hw_op(hw_op), .ctl_lines(ctl_lines)
  );

  always @(posedge clk) begin
    n_cyc = n_cyc + 1;
    if (n_cyc > WATCHDOG) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", n_cyc, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // group map restated from R3/R4
  function automatic logic [14:0] ref_lines(logic irq, logic [7:0] op);
    logic [14:0] r;
    r = '0;
    if (irq) return K_IRQ;
    case (op[7:4])
      4'h0, 4'h1, 4'h2, 4'h3:
        if (!op[2])      r = K_ALU | K_MRM | K_W | K_D;
        else if (!op[1]) r = K_ALU | K_W | K_ACC | K_IMM;
        else             r = K_SEG;
      4'h4: r = K_REG | K_ALU;
      4'h5: r = K_REG;
      4'h6, 4'h7: r = K_BR | K_IMM;
      4'h8: r = K_MRM | K_W | K_D;
      4'h9: r = op[3] ? K_HW : (K_REG | K_ACC);
      4'hA: r = K_STR | K_W;
      4'hB: r = K_REG | K_IMM | K_W3;
      4'hC, 4'hE: r = K_BR;
      4'hD: r = K_ALU | K_MRM | K_W;
      default: begin
        if (op[3:0] <= 4'h3)                       r = K_PFX | K_HW;
        else if (op[3:0] == 4'h4)                  r = K_HLT;
        else if (op[3:0] == 4'h5)                  r = K_HW;
        else if (op[3:0] <= 4'h7)                  r = K_ALU | K_MRM | K_W;
        else if (op[3:0] <= 4'hD)                  r = K_HW;
        else                                       r = K_MRM | K_W;
      end
    endcase
    return r;
  endfunction

  // dispatch one opcode; called and returns at a negedge with the block idle
  task automatic run_op(input logic irq, input logic [7:0] op, input int w,
                        input logic [14:0] exp_lines, input bit intrude);
    bit   fired = 0;
    bit   saw_sub = 0;
    int   subs = 0;
    int   cyc;
    bit   exp_hw  = exp_lines[0];
    bit   exp_sub = exp_lines[2];
    int   exp_cyc = exp_lines[2] ? 3 + w : 2;
    op_valid = 1'b1; op_byte = op; irq_req = irq;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0; op_byte = ~op; irq_req = ~irq;
    cyc = 1;
    chk(op_ready == 1'b0, "R1", "ready while busy", op_ready, 0);
    while (!fired && cyc < 80) begin
      op_valid = 1'b0;
      if (asub_req) begin
        saw_sub = 1;
        asub_done = (subs == w);
        if (intrude && subs == 1) begin op_valid = 1'b1; op_byte = 8'h9C; end
        subs++;
      end else asub_done = 1'b0;
      if (uc_start || hw_fire) fired = 1;
      else begin @(negedge clk); cyc++; end
    end
    asub_done = 1'b0;
    chk(ctl_lines == exp_lines, "R3", "lines", ctl_lines, exp_lines);
    chk(cyc == exp_cyc, exp_sub ? "R7" : (exp_hw ? "R5" : "R6"), "dispatch cycle", cyc, exp_cyc);
    chk(saw_sub == exp_sub, irq ? "R4" : "R7", "addressing call", saw_sub, exp_sub);
    if (exp_hw) begin
      chk(hw_fire && !uc_start, "R5", "hardwired pulse", hw_fire, 1);
      chk(hw_op == op, "R5", "hw_op", hw_op, op);
    end else begin
      chk(uc_start && !hw_fire, "R6", "micro pulse", uc_start, 1);
      chk(uc_addr == (irq ? 9'h100 : {1'b0, op}), irq ? "R4" : "R1", "uc_addr",
          uc_addr, irq ? 9'h100 : {1'b0, op});
    end
    @(negedge clk);
    chk(op_ready && !uc_start && !hw_fire, "R8", "return to idle", op_ready, 1);
  endtask

  initial begin
    // reset state (R9)
    repeat (3) @(negedge clk);
    chk(op_ready == 1'b1, "R9", "ready in reset", op_ready, 1);
    chk({uc_start, hw_fire, asub_req} == 3'b000, "R9", "pulses in reset",
        {uc_start, hw_fire, asub_req}, 0);
    chk(ctl_lines == '0, "R9", "lines in reset", ctl_lines, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(op_ready && ctl_lines == '0, "R9", "state after reset", ctl_lines, 0);

    // directed vector table (R2, R3, R4)
    for (int i = 0; i < 15; i++)
      run_op(VEC[i][23], VEC[i][22:15], i % 4, VEC[i][14:0], 1'b0);

    // stray done while idle is ignored (R7)
    asub_done = 1'b1;
    @(negedge clk);
    asub_done = 1'b0;
    chk(op_ready && !uc_start && !asub_req, "R7", "done while idle", uc_start, 0);
    @(negedge clk);
    chk(op_ready && !uc_start && !hw_fire, "R7", "done while idle later", uc_start, 0);

    // stray opcode offered during the addressing call is ignored (R1)
    run_op(1'b0, 8'h01, 3, 15'h008E, 1'b1);
    @(negedge clk);
    chk(op_ready && !uc_start && !hw_fire && !asub_req, "R1", "no second dispatch",
        {uc_start, hw_fire, asub_req}, 0);

    // all 512 flag/opcode combinations (R3, R4, R5, R6, R7)
    for (int k = 0; k < 512; k++) begin
      logic [8:0] iv;
      iv = 9'(k);
      run_op(iv[8], iv[7:0], k % 3, ref_lines(iv[8], iv[7:0]), 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule